// File: doc/BRIEF.md
# Processor Status Flag Register

A 16-bit processor status word for a small CPU core. It holds the four arithmetic flags (carry, zero, sign, overflow), a debug bit, a register-bank bit, a maskable-interrupt enable, a stack select bit and a 3-bit interrupt priority level. The execution unit updates the arithmetic flags after each instruction. Privileged code can load the whole word. The current word is always visible on the output for reads and for stacking.

The block also decides whether a pending maskable interrupt may be taken. A request is accepted only when interrupts are enabled and the request level is strictly above the current priority level. When the core takes a hardware interrupt (acknowledge strobe), the enable bit is cleared and the interrupt stack is selected. A software interrupt instruction also clears the enable bit. It switches to the interrupt stack only for low vector numbers.

Top module: `psw_reg`

## Requirements
- R1: After reset the word reads 0x0000: interrupts disabled, priority level 0, interrupt stack selected.
- R2: A full write (`wr_en`) loads bits 0-7 and 12-14 from `wr_data` on the next clock edge. Bits 8-11 and 15 are reserved, always read 0, and ignore writes.
- R3: With `flag_upd_en` high, `flag_val` = {overflow, sign, zero, carry} is loaded into bits 5, 3, 2 and 0, and no other bit changes. In a cycle that also has a full write, these four bits take `flag_val`.
- R4: `irq_accept` is high, in the same cycle, exactly when bit 6 is 1, `irq_req` is 1 and `irq_lvl` is strictly greater than bits 14:12.
- R5: While bit 6 (interrupt enable) is 0, `irq_accept` stays 0 for every request level.
- R6: A `hw_ack` pulse clears bit 6 and bit 7 on the next edge. This overrides a full write in the same cycle.
- R7: A `swint` pulse clears bit 6 on the next edge. It also clears bit 7 when `swint_num` is below 32.
- R8: A `swint` pulse with `swint_num` of 32 or more leaves bit 7 as it was.
- R9: `user_sp_sel` equals bit 7: 1 selects the user stack pointer and 0 selects the interrupt stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 16 | Full-word write data |
| flag_upd_en | input | 1 | Arithmetic flag update strobe |
| flag_val | input | 4 | {overflow, sign, zero, carry} from execution |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_lvl | input | 3 | Priority of the pending request |
| hw_ack | input | 1 | Hardware interrupt acknowledge strobe |
| swint | input | 1 | Software interrupt instruction strobe |
| swint_num | input | VEC_W | Software interrupt vector number |
| psw | output | 16 | Current status word |
| irq_accept | output | 1 | Pending request may be taken |
| user_sp_sel | output | 1 | 1 = user stack, 0 = interrupt stack |

## Verification
Every bit of the status word is on `psw`. A wrong internal bit therefore shows at the ports on the first clock after the faulty update, and the bench compares it against its model on every cycle. A wrong enable bit or priority level shows in the same cycle on `irq_accept` once a request with a level near the boundary is presented, so the stimulus sweeps request levels just above, equal to and below the level. The collisions of a write with an acknowledge, with a flag update and with software interrupts at vector 31 and 32 are driven on purpose.

// File: rtl/psw_reg.sv
module psw_reg #(
  parameter int VEC_W     = 6,
  parameter int LOW_VECS  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             flag_upd_en,
  input  logic [3:0]       flag_val,
  input  logic             irq_req,
  input  logic [2:0]       irq_lvl,
  input  logic             hw_ack,
  input  logic             swint,
  input  logic [VEC_W-1:0] swint_num,
  output logic [15:0]      psw,
  output logic             irq_accept,
  output logic             user_sp_sel
);
  localparam logic [15:0]  WR_MASK = 16'h70FF;
  localparam logic [VEC_W:0] LOW_LIM = LOW_VECS[VEC_W:0];

  logic [15:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wr_data & WR_MASK;
    if (flag_upd_en) {word_d[5], word_d[3], word_d[2], word_d[0]} = flag_val;
    if (swint) begin
      word_d[6] = 1'b0;
      if ({1'b0, swint_num} < LOW_LIM) word_d[7] = 1'b0;
    end
    if (hw_ack) word_d[7:6] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;

  assign psw         = word_q;
  assign user_sp_sel = word_q[7];
  assign irq_accept  = word_q[6] & irq_req & (irq_lvl > word_q[14:12]);
endmodule

module psw_reg_chk #(parameter int VEC_W = 6) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             flag_upd_en,
  input logic [3:0]       flag_val,
  input logic             hw_ack,
  input logic             swint,
  input logic [VEC_W-1:0] swint_num,
  input logic [15:0]      psw,
  input logic             irq_accept,
  input logic             user_sp_sel
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw[11:8] == 4'h0 && !psw[15]);
  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psw[6] |-> !irq_accept);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> !psw[6] && !psw[7]);
  // R7
  swint_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swint && (swint_num < 32) |=> !psw[7] && !psw[6]);
  // R8
  swint_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swint && (swint_num >= 32) && !hw_ack && !wr_en |=> psw[7] == $past(psw[7]));
  // R3
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd_en |=> {psw[5], psw[3], psw[2], psw[0]} == $past(flag_val));
  // R9
  stack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_sp_sel == psw[7]);
endmodule

bind psw_reg psw_reg_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flag_upd_en(flag_upd_en),
  .flag_val(flag_val), .hw_ack(hw_ack), .swint(swint), .swint_num(swint_num),
  .psw(psw), .irq_accept(irq_accept), .user_sp_sel(user_sp_sel));

// File: tb/psw_reg_tb.sv
module psw_reg_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, flag_upd_en = 0, irq_req = 0, hw_ack = 0, swint = 0;
  logic [15:0] wr_data = '0;
  logic [3:0]  flag_val = '0;
  logic [2:0]  irq_lvl = '0;
  logic [5:0]  swint_num = '0;
  logic [15:0] psw;
  logic irq_accept, user_sp_sel;

  int checks = 0, errors = 0;
  int model = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psw_reg u_dut (.clk, .rst_n, .wr_en, .wr_data, .flag_upd_en, .flag_val,
    .irq_req, .irq_lvl, .hw_ack, .swint, .swint_num, .psw, .irq_accept, .user_sp_sel);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_accept(int req, int lvl);
    int ie  = (model / 64) % 2;
    int ipl = (model / 4096) % 8;
    return (ie == 1 && req == 1 && lvl > ipl) ? 1 : 0;
  endfunction

  function automatic int set_bit(int v, int pos, int b);
    int p = 1 << pos;
    return b ? (v | p) : (v & ~p);
  endfunction

  // drive at negedge, check comb now, clock, check state at next negedge
  task automatic step(string tag, bit we, int wd, bit fu, int fv, bit rq, int lv,
                      bit ak, bit si, int sn);
    int nxt;
    wr_en = we; wr_data = wd[15:0]; flag_upd_en = fu; flag_val = fv[3:0];
    irq_req = rq; irq_lvl = lv[2:0]; hw_ack = ak; swint = si; swint_num = sn[5:0];
    #1;
    chk({tag, " R4 accept"}, int'(irq_accept), exp_accept(rq, lv));
    nxt = model;
    if (we) nxt = wd & ('hFF + 'h7000);
    if (fu) begin
      nxt = set_bit(nxt, 0, fv % 2);
      nxt = set_bit(nxt, 2, (fv / 2) % 2);
      nxt = set_bit(nxt, 3, (fv / 4) % 2);
      nxt = set_bit(nxt, 5, (fv / 8) % 2);
    end
    if (si) begin
      nxt = set_bit(nxt, 6, 0);
      if (sn < 32) nxt = set_bit(nxt, 7, 0);
    end
    if (ak) begin nxt = set_bit(nxt, 6, 0); nxt = set_bit(nxt, 7, 0); end
    @(posedge clk); model = nxt;
    @(negedge clk);
    chk({tag, " word"}, int'(psw), model);
    chk({tag, " R9 stack select"}, int'(user_sp_sel), (model / 128) % 2);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", int'(psw), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(psw), 0);
    // R5: disabled, every level blocked
    for (int l = 0; l < 8; l++) step("R5 blocked", 0, 0, 0, 0, 1, l, 0, 0, 0);
    // R2: write all ones, reserved read 0
    step("R2 write ones", 1, 'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 reserved zero", int'(psw), 'h70FF);
    // R4: IPL 3 enabled, sweep levels
    step("R2 write ipl3", 1, 'h3040, 0, 0, 0, 0, 0, 0, 0);
    for (int l = 0; l < 8; l++) step("R4 sweep", 0, 0, 0, 0, 1, l, 0, 0, 0);
    step("R4 no request", 0, 0, 0, 0, 0, 7, 0, 0, 0);
    // R3: flag update alone and against write
    step("R3 flags", 0, 0, 1, 'hA, 0, 0, 0, 0, 0);
    step("R3 flags vs write", 1, 'h00FF, 1, 'h0, 0, 0, 0, 0, 0);
    chk("R3 write lost flags", int'(psw) & 'h2D, 0);
    // R6: ack overrides write of I and U
    step("R6 ack vs write", 1, 'h70C0, 0, 0, 1, 7, 1, 0, 0);
    chk("R6 cleared", int'(psw) & 'hC0, 0);
    // R7 / R8: boundary 31 / 32
    step("R7 set U", 1, 'h00C0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 swint 32", 0, 0, 0, 0, 0, 0, 0, 1, 32);
    chk("R8 U kept", int'(user_sp_sel), 1);
    step("R7 reenable", 1, 'h00C0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 swint 31", 0, 0, 0, 0, 0, 0, 0, 1, 31);
    chk("R7 U cleared", int'(psw) & 'hC0, 0);
    step("R8 high 63", 1, 'h0080, 0, 0, 0, 0, 0, 1, 63);
    chk("R8 U from write kept", int'(user_sp_sel), 1);
    // mixed stimulus, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      step("R2 R3 R6 R7 mix", r[0] & r[1], $urandom, r[2], r[7:4], r[3], r[10:8],
           (r[15:11] == 0), (r[20:17] == 0), r[26:21]);
    end
    idle("end");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule